// File: doc/BRIEF.md
# Dual-Port Contention Busy Arbiter

This block sits between the two access ports of a shared dual-port memory and resolves collisions on a single location. Each side, called left and right, presents an active-low chip enable, a write strobe, an output enable, an address and write data. A collision exists when both sides are enabled on the same address. In that case the block chooses one side to keep the location. It then drives an active-low busy flag toward the other side and suppresses any write that side attempts.

A mode input selects between two roles. In master mode the block arbitrates on its own and presents the result on its busy outputs. In slave mode it ignores its own arbitration. It takes the busy flags from a master's outputs and mirrors them, so a row of devices placed side by side to widen the data word follows one decision. A small behavioural 4K x 16 array stands in for the storage so that write gating can be observed through reads.

Top module: `dpc_contend_arb`

## Requirements
- R1: While reset is held low, and in the first cycle after it, both busy outputs read 1 (inactive) and both read data outputs read 0.
- R2: Busy is never raised when the two ports are enabled on different addresses, or when only one port is enabled, and both writes commit.
- R3: In master mode, when both ports become enabled on the same address in the same cycle, the left port wins. busy_r_n goes low in the cycle after the match is first presented and stays high in the cycle the match is presented. busy_l_n stays high.
- R4: In master mode, if one port was enabled on an address in the previous cycle and the other port was not, and the other port now arrives on that address, the earlier port wins and the newcomer sees busy.
- R5: In master mode the winner keeps the location as long as the match persists, even after both ports have been holding it. Both busy outputs return high in the cycle after the match ends.
- R6: In master mode a write from the losing port is not committed, including in the first cycle of the collision before busy is visible. The winner's write commits.
- R7: In slave mode busy_l_n and busy_r_n follow busy_in_l_n and busy_in_r_n. A port write is committed only while its busy input is high, and the block's own arbitration has no effect.
- R8: A read (port enabled, write strobe low) returns the stored word on rdata one cycle later while that port's output enable is high. rdata reads 0 while the output enable is low.
- R9: In master mode at most one busy output is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1 = master (arbitrate), 0 = slave (follow busy inputs) |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_wr | input | 1 | Left write strobe, 1 = write |
| l_oe | input | 1 | Left output enable, active high |
| l_addr | input | 12 | Left address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_wr | input | 1 | Right write strobe, 1 = write |
| r_oe | input | 1 | Right output enable, active high |
| r_addr | input | 12 | Right address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |
| busy_in_l_n | input | 1 | Slave-mode busy input for left, active low |
| busy_in_r_n | input | 1 | Slave-mode busy input for right, active low |
| busy_l_n | output | 1 | Busy toward left, active low |
| busy_r_n | output | 1 | Busy toward right, active low |

## Verification
Arbitration is driven with four patterns. Simultaneous arrival on one address checks the left-wins tie break. A staggered arrival, with right first, shows that earlier presence beats the tie rule. Different addresses with both ports enabled separate a true address match from mere double enable. A long hold followed by one port leaving checks that ownership is retained and released one cycle later. Both sides write in every collision, and read-back tells which write was kept, including the first cycle before busy appears. Slave mode is driven with busy inputs that disagree with the local address match, which shows that the local arbitration has no effect there.

// File: rtl/dpc_pkg.sv
// Shared types for the dual-port contention arbiter.
package dpc_pkg;
    // Which port currently holds a contended location.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } own_e;
endpackage

// File: rtl/dpc_match.sv
// Address-match detector.
// Flags a collision when both ports are enabled on one address. It also
// reports, for each port, whether that port was already enabled on its
// present address in the previous cycle (used to order late arrivals).
// Assumes enables are active high here; the top inverts the pins.
module dpc_match #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_l,
    input  logic              en_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    output logic              match,
    output logic              held_l,
    output logic              held_r
);
    logic              prev_en_l, prev_en_r;
    logic [ADDR_W-1:0] prev_addr_l, prev_addr_r;

    // Remember last cycle's enable and address of each port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_en_l   <= 1'b0;
            prev_en_r   <= 1'b0;
            prev_addr_l <= '0;
            prev_addr_r <= '0;
        end else begin
            prev_en_l   <= en_l;
            prev_en_r   <= en_r;
            prev_addr_l <= addr_l;
            prev_addr_r <= addr_r;
        end
    end

    // Collision and prior-presence decode.
    always_comb begin
        match  = en_l && en_r && (addr_l == addr_r);
        held_l = prev_en_l && (prev_addr_l == addr_l);
        held_r = prev_en_r && (prev_addr_r == addr_r);
    end
endmodule

// File: rtl/dpc_owner.sv
// Ownership state for a contended location.
// The next owner is chosen when a match appears. Right wins only when it
// was present alone a cycle earlier; otherwise left wins. The owner is kept
// until the match disappears. owner_q is the registered result that busy
// is built from; owner_nx gates writes in the same cycle.
module dpc_owner
    import dpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic held_l,
    input  logic held_r,
    output own_e owner_q,
    output own_e owner_nx
);
    // Next-owner selection.
    always_comb begin
        if (!match)
            owner_nx = OWN_NONE;
        else if (owner_q != OWN_NONE)
            owner_nx = owner_q;
        else if (held_r && !held_l)
            owner_nx = OWN_RIGHT;
        else
            owner_nx = OWN_LEFT;
    end

    // Ownership register.
    always_ff @(posedge clk) begin
        if (!rst_n) owner_q <= OWN_NONE;
        else        owner_q <= owner_nx;
    end
endmodule

// File: rtl/dpc_mem.sv
// Behavioural two-port storage array with registered read data.
// Each port reads or writes one word per cycle. Assumes the two ports
// never write one address in the same cycle (the arbiter prevents it).
module dpc_mem #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_l,
    input  logic              we_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [DATA_W-1:0] wdata_l,
    output logic [DATA_W-1:0] rdata_l,
    input  logic              rd_r,
    input  logic              we_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] wdata_r,
    output logic [DATA_W-1:0] rdata_r
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Array writes from both ports.
    always_ff @(posedge clk) begin
        if (we_l) store[addr_l] <= wdata_l;
        if (we_r) store[addr_r] <= wdata_r;
    end

    // Registered read data per port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_l <= '0;
            rdata_r <= '0;
        end else begin
            if (rd_l) rdata_l <= store[addr_l];
            if (rd_r) rdata_r <= store[addr_r];
        end
    end
endmodule

// File: rtl/dpc_contend_arb.sv
// Dual-port contention arbiter, top level.
// Master mode: arbitrates collisions and drives active-low busy flags.
// Slave mode: mirrors busy inputs from a master. In both modes writes
// from a busy port are dropped. Read data appears one cycle after a read
// and is shown only while the output enable is high.
module dpc_contend_arb
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_ce_n,
    input  logic              l_wr,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_ce_n,
    input  logic              r_wr,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    input  logic              busy_in_l_n,
    input  logic              busy_in_r_n,
    output logic              busy_l_n,
    output logic              busy_r_n
);
    logic              en_l, en_r;
    logic              match, held_l, held_r;
    own_e              owner_q, owner_nx;
    logic              l_we_eff, r_we_eff;
    logic [DATA_W-1:0] l_rq, r_rq;

    assign en_l = ~l_ce_n;
    assign en_r = ~r_ce_n;

    dpc_match #(.ADDR_W(ADDR_W)) match_i (
        .clk(clk), .rst_n(rst_n),
        .en_l(en_l), .en_r(en_r),
        .addr_l(l_addr), .addr_r(r_addr),
        .match(match), .held_l(held_l), .held_r(held_r)
    );

    dpc_owner owner_i (
        .clk(clk), .rst_n(rst_n),
        .match(match), .held_l(held_l), .held_r(held_r),
        .owner_q(owner_q), .owner_nx(owner_nx)
    );

    // Busy path: local result in master mode, forwarded input in slave mode.
    always_comb begin
        if (master_mode) begin
            busy_l_n = (owner_q != OWN_RIGHT);
            busy_r_n = (owner_q != OWN_LEFT);
        end else begin
            busy_l_n = busy_in_l_n;
            busy_r_n = busy_in_r_n;
        end
    end

    // Write gating: drop writes from the port that loses (or is told busy).
    always_comb begin
        if (master_mode) begin
            l_we_eff = en_l && l_wr && (owner_nx != OWN_RIGHT);
            r_we_eff = en_r && r_wr && (owner_nx != OWN_LEFT);
        end else begin
            l_we_eff = en_l && l_wr && busy_in_l_n;
            r_we_eff = en_r && r_wr && busy_in_r_n;
        end
    end

    dpc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
        .clk(clk), .rst_n(rst_n),
        .rd_l(en_l && !l_wr), .we_l(l_we_eff), .addr_l(l_addr),
        .wdata_l(l_wdata), .rdata_l(l_rq),
        .rd_r(en_r && !r_wr), .we_r(r_we_eff), .addr_r(r_addr),
        .wdata_r(r_wdata), .rdata_r(r_rq)
    );

    // Output-enable gating of read data.
    assign l_rdata = l_oe ? l_rq : '0;
    assign r_rdata = r_oe ? r_rq : '0;
endmodule

// File: rtl/dpc_arb_chk.sv
// Assertion checker for dpc_contend_arb, bound to every instance.
module dpc_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic master_mode,
    input logic match,
    input logic busy_l_n,
    input logic busy_r_n,
    input logic busy_in_l_n,
    input logic l_we_eff,
    input logic r_we_eff,
    input logic l_ce_n,
    input logic r_ce_n
);
    // R9: never both busy in master mode.
    a_r9_one_busy: assert property (@(posedge clk) disable iff (!rst_n)
        master_mode |-> !(!busy_l_n && !busy_r_n));

    // R3: a match leads to a busy flag on the next cycle.
    a_r3_busy_follows_match: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && match) |=> (!master_mode || !busy_l_n || !busy_r_n));

    // R5: no match means both busy flags released next cycle.
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !match) |=> (!master_mode || (busy_l_n && busy_r_n)));

    // R5: the winner on the left keeps access while the match holds.
    a_r5_keep_left: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && match && !busy_r_n) |=> (!master_mode || !match || !busy_r_n));

    // R7: slave-mode writes on the left need a high busy input.
    a_r7_slave_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !busy_in_l_n) |-> !l_we_eff);

    // R6: a collision never lets both writes through in master mode.
    a_r6_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && match) |-> !(l_we_eff && r_we_eff));

    // R2: a write needs its own chip enable.
    a_r2_write_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce_n |-> !l_we_eff) and (r_ce_n |-> !r_we_eff));
endmodule

bind dpc_contend_arb dpc_arb_chk chk_i (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .match(match),
    .busy_l_n(busy_l_n), .busy_r_n(busy_r_n), .busy_in_l_n(busy_in_l_n),
    .l_we_eff(l_we_eff), .r_we_eff(r_we_eff),
    .l_ce_n(l_ce_n), .r_ce_n(r_ce_n)
);

// File: tb/dpc_contend_arb_tb_top.sv
`timescale 1ns/1ps
module dpc_contend_arb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_mode = 1'b1;
    logic        l_ce_n = 1'b1, l_wr = 1'b0, l_oe = 1'b1;
    logic [11:0] l_addr = '0;
    logic [15:0] l_wdata = '0, l_rdata;
    logic        r_ce_n = 1'b1, r_wr = 1'b0, r_oe = 1'b1;
    logic [11:0] r_addr = '0;
    logic [15:0] r_wdata = '0, r_rdata;
    logic        busy_in_l_n = 1'b1, busy_in_r_n = 1'b1;
    logic        busy_l_n, busy_r_n;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    dpc_contend_arb dut_i (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_ce_n(l_ce_n), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_ce_n(r_ce_n), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata),
        .busy_in_l_n(busy_in_l_n), .busy_in_r_n(busy_in_r_n),
        .busy_l_n(busy_l_n), .busy_r_n(busy_r_n)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        l_ce_n = 1'b1; l_wr = 1'b0;
        r_ce_n = 1'b1; r_wr = 1'b0;
    endtask

    // One-port write in one cycle, then idle.
    task automatic wr_left(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk); l_ce_n = 1'b0; l_wr = 1'b1; l_addr = a; l_wdata = d;
        @(negedge clk); idle();
    endtask

    // Read through the left port; data sampled one cycle later.
    task automatic rd_left(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk); l_ce_n = 1'b0; l_wr = 1'b0; l_oe = 1'b1; l_addr = a;
        @(negedge clk); d = l_rdata; idle();
    endtask

    task automatic t_reset();
        check("R1 busy_l_n in reset", {15'd0, busy_l_n}, 16'd1);
        check("R1 busy_r_n in reset", {15'd0, busy_r_n}, 16'd1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 l_rdata after reset", l_rdata, 16'h0000);
        check("R1 r_rdata after reset", r_rdata, 16'h0000);
        check("R1 busy pair after reset", {14'd0, busy_l_n, busy_r_n}, 16'd3);
    endtask

    task automatic t_r2_no_match();
        logic [15:0] d;
        @(negedge clk);
        l_ce_n = 1'b0; l_wr = 1'b1; l_addr = 12'h010; l_wdata = 16'h1010;
        r_ce_n = 1'b0; r_wr = 1'b1; r_addr = 12'h011; r_wdata = 16'h1111;
        @(negedge clk);
        check("R2 no busy on different addresses", {14'd0, busy_l_n, busy_r_n}, 16'd3);
        idle();
        @(negedge clk);
        check("R2 still no busy", {14'd0, busy_l_n, busy_r_n}, 16'd3);
        rd_left(12'h010, d); check("R2 left write kept", d, 16'h1010);
        rd_left(12'h011, d); check("R2 right write kept", d, 16'h1111);
    endtask

    task automatic t_r3_tie();
        logic [15:0] d;
        @(negedge clk);
        l_ce_n = 1'b0; l_wr = 1'b1; l_addr = 12'h0A0; l_wdata = 16'hAAAA;
        r_ce_n = 1'b0; r_wr = 1'b1; r_addr = 12'h0A0; r_wdata = 16'hBBBB;
        #1 check("R3 busy_r_n high in first match cycle", {15'd0, busy_r_n}, 16'd1);
        @(negedge clk);
        check("R3 busy_r_n low after tie", {15'd0, busy_r_n}, 16'd0);
        check("R3 busy_l_n high after tie", {15'd0, busy_l_n}, 16'd1);
        idle();
        @(negedge clk);
        rd_left(12'h0A0, d); check("R6 tie keeps left write only", d, 16'hAAAA);
    endtask

    task automatic t_r4_r5_late();
        logic [15:0] d;
        @(negedge clk);
        r_ce_n = 1'b0; r_wr = 1'b0; r_addr = 12'h0B0;
        @(negedge clk);
        check("R4 single port no busy", {14'd0, busy_l_n, busy_r_n}, 16'd3);
        l_ce_n = 1'b0; l_wr = 1'b1; l_addr = 12'h0B0; l_wdata = 16'hCCCC;
        r_wr = 1'b1; r_wdata = 16'h5555;
        @(negedge clk);
        check("R4 late left sees busy", {15'd0, busy_l_n}, 16'd0);
        check("R4 earlier right not busy", {15'd0, busy_r_n}, 16'd1);
        l_wdata = 16'hDDDD; r_wdata = 16'h6666;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R5 right keeps ownership", {14'd0, busy_l_n, busy_r_n}, 16'd1);
        end
        l_addr = 12'h0B1; l_wr = 1'b0;
        #1 check("R5 busy held in cycle match ends", {15'd0, busy_l_n}, 16'd0);
        @(negedge clk);
        check("R5 busy released after match ends", {14'd0, busy_l_n, busy_r_n}, 16'd3);
        idle();
        rd_left(12'h0B0, d); check("R6 loser writes dropped", d, 16'h6666);
    endtask

    task automatic t_r8_oe();
        logic [15:0] d;
        wr_left(12'h0C0, 16'h0C0C);
        @(negedge clk); l_ce_n = 1'b0; l_wr = 1'b0; l_oe = 1'b0; l_addr = 12'h0C0;
        @(negedge clk);
        check("R8 rdata zero with oe low", l_rdata, 16'h0000);
        l_oe = 1'b1; idle();
        #1 check("R8 rdata shown with oe high", l_rdata, 16'h0C0C);
        rd_left(12'h0C0, d); check("R8 read returns stored word", d, 16'h0C0C);
    endtask

    task automatic t_r7_slave();
        logic [15:0] d;
        @(negedge clk);
        master_mode = 1'b0; busy_in_l_n = 1'b0; busy_in_r_n = 1'b1;
        #1 check("R7 slave mirrors busy inputs", {14'd0, busy_l_n, busy_r_n}, 16'd1);
        l_ce_n = 1'b0; l_wr = 1'b1; l_addr = 12'h0C0; l_wdata = 16'h7777;
        @(negedge clk); idle();
        rd_left(12'h0C0, d); check("R7 busy input blocks left write", d, 16'h0C0C);
        @(negedge clk); busy_in_l_n = 1'b1;
        l_ce_n = 1'b0; l_wr = 1'b1; l_addr = 12'h0C0; l_wdata = 16'h7777;
        r_ce_n = 1'b0; r_wr = 1'b0; r_addr = 12'h0C0;
        @(negedge clk);
        check("R7 local match ignored in slave", {14'd0, busy_l_n, busy_r_n}, 16'd3);
        idle();
        rd_left(12'h0C0, d); check("R7 write with busy input high", d, 16'h7777);
        @(negedge clk); master_mode = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_r2_no_match();
        t_r3_tie();
        t_r4_r5_late();
        t_r8_oe();
        t_r7_slave();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule